// File: doc/BRIEF.md
# Five-Operand Modular Adder with Column Counters

This block adds five unsigned W-bit operands and returns their sum modulo 2^W in the same cycle. It has no registers. Each bit position feeds its five operand bits into a small 5-input ones counter, which gives a 3-bit count. The three count vectors carry weights 1, 2 and 4. One carry-save stage reduces them to two vectors, and a ripple carry-propagate adder turns those two vectors into the result. Any bit that would land above position W-1 is dropped, whether it comes from the weight shifts, the carry-save stage or the final adder.

A parameter selects the datapath variant. The default is the column-counter datapath. The other variant chains three carry-save stages over the raw operands, followed by the same final adder, and must produce identical results. It suits designs that need the sum of several small values taken modulo a power of two, such as running accumulators, checksum folding and averaging front ends.

Top module: `madd5_mod_adder`

## Requirements
- R1: For any five W-bit unsigned inputs, `y` equals (a+b+c+d+e) mod 2^W in the same cycle.
- R2: If the same single bit position i is set in exactly k of the five operands and all other bits are zero, `y` equals (k·2^i) mod 2^W, for every k from 1 to 5.
- R3: Carries out of bit W-1 are discarded. With all inputs all-ones, `y` equals 5·(2^W−1) mod 2^W, which is 251 for W=8.
- R4: Count bits of weight 2 and 4 that would fall above position W-1 are truncated before the carry-save stage. With five operands equal to 2^(W-1), `y` equals 2^(W-1).
- R5: The carry-save-chain variant (ARCH = ARCH_CSA_CHAIN) produces the same `y` as the column-counter variant for every input.
- R6: With all five inputs zero, `y` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | First unsigned operand |
| b | input | W | Second unsigned operand |
| c | input | W | Third unsigned operand |
| d | input | W | Fourth unsigned operand |
| e | input | W | Fifth unsigned operand |
| y | output | W | Sum of the five operands modulo 2^W |

## Verification
Two truncations can act in the same evaluation. The first drops weight-2 and weight-4 count bits shifted past the top column. The second drops the carry out of the final adder. All-ones operands provoke both at once, and so do full columns at the top bit positions. Each result is judged against the sum computed in the bench and reduced modulo 2^W. A second instance built as the carry-save chain is fed the same stimulus and is held to the same expected value.

// File: rtl/madd5_pkg.sv
`timescale 1ns/1ps
package madd5_pkg;

    // Datapath variant selector
    typedef enum logic [0:0] {
        ARCH_COUNTER   = 1'b0,
        ARCH_CSA_CHAIN = 1'b1
    } arch_e;

    // 3-bit count of ones in a column: value = 4*w4 + 2*w2 + w1
    typedef struct packed {
        logic w4;
        logic w2;
        logic w1;
    } col_cnt_t;

    // Explicit 5-input ones counter built from two full-adder cells
    function automatic col_cnt_t count_ones5(input logic [4:0] bits);
        col_cnt_t r;
        logic     t_lo;
        logic     k_lo;
        logic     k_hi;
        t_lo = bits[0] ^ bits[1] ^ bits[2];
        k_lo = (bits[0] & bits[1]) | (bits[0] & bits[2]) | (bits[1] & bits[2]);
        r.w1 = t_lo ^ bits[3] ^ bits[4];
        k_hi = (t_lo & bits[3]) | (t_lo & bits[4]) | (bits[3] & bits[4]);
        r.w2 = k_lo ^ k_hi;
        r.w4 = k_lo & k_hi;
        return r;
    endfunction

endpackage

// File: rtl/madd5_col_counter.sv
`timescale 1ns/1ps
module madd5_col_counter
    import madd5_pkg::*;
(
    input  logic [4:0] col_bits,
    output col_cnt_t   col_cnt
);

    always_comb begin
        col_cnt = count_ones5(col_bits);
    end

    always_comb begin
        if (!$isunknown(col_bits)) begin
            assert_col_count_R2: assert ({col_cnt.w4, col_cnt.w2, col_cnt.w1} == 3'($countones(col_bits)))
                else $error("column count mismatch");
        end
    end

endmodule

// File: rtl/madd5_counter_layer.sv
`timescale 1ns/1ps
module madd5_counter_layer
    import madd5_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [4:0][W-1:0] ops,
    output logic [W-1:0]      v1,
    output logic [W-1:0]      v2,
    output logic [W-1:0]      v4
);

    col_cnt_t [W-1:0] cnts;

    for (genvar i = 0; i < W; i++) begin : g_col
        madd5_col_counter u_col (
            .col_bits ({ops[4][i], ops[3][i], ops[2][i], ops[1][i], ops[0][i]}),
            .col_cnt  (cnts[i])
        );
        assign v1[i] = cnts[i].w1;
        assign v2[i] = cnts[i].w2;
        assign v4[i] = cnts[i].w4;
    end

endmodule

// File: rtl/madd5_csa.sv
`timescale 1ns/1ps
module madd5_csa #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] z,
    output logic [W-1:0] sum,
    output logic [W-1:0] carry
);

    logic [W-1:0] maj;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i] = x[i] ^ y[i] ^ z[i];
        assign maj[i] = (x[i] & y[i]) | (x[i] & z[i]) | (y[i] & z[i]);
    end

    // carry vector weighted by 2, top bit discarded
    assign carry = W'({maj, 1'b0});

    always_comb begin
        if (!$isunknown({x, y, z})) begin
            assert_csa_keeps_sum_R4: assert (W'(sum + carry) == W'(x + y + z))
                else $error("carry-save stage lost value");
        end
    end

endmodule

// File: rtl/madd5_cpa.sv
`timescale 1ns/1ps
module madd5_cpa #(
    parameter int W = 8
) (
    input  logic [W-1:0] p,
    input  logic [W-1:0] q,
    output logic [W-1:0] sum
);

    logic [W-1:0] cin;

    assign cin[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_fa
        assign sum[i] = p[i] ^ q[i] ^ cin[i];
        if (i < W - 1) begin : g_carry
            assign cin[i+1] = (p[i] & q[i]) | (p[i] & cin[i]) | (q[i] & cin[i]);
        end
    end

    always_comb begin
        if (!$isunknown({p, q})) begin
            assert_cpa_drops_carry_R3: assert (sum == W'(p + q))
                else $error("final adder result wrong");
        end
    end

endmodule

// File: rtl/madd5_mod_adder.sv
`timescale 1ns/1ps
module madd5_mod_adder
    import madd5_pkg::*;
#(
    parameter int    W    = 8,
    parameter arch_e ARCH = ARCH_COUNTER
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    input  logic [W-1:0] d,
    input  logic [W-1:0] e,
    output logic [W-1:0] y
);

    logic [W-1:0] fin_p;
    logic [W-1:0] fin_q;

    if (ARCH == ARCH_COUNTER) begin : g_counter
        logic [W-1:0] v1, v2, v4;
        logic [W-1:0] v2_w, v4_w;

        madd5_counter_layer #(.W(W)) u_layer (
            .ops ({e, d, c, b, a}),
            .v1  (v1),
            .v2  (v2),
            .v4  (v4)
        );

        // apply column weights, dropping bits past the top position
        assign v2_w = W'({v2, 1'b0});
        assign v4_w = W'({v4, 2'b00});

        madd5_csa #(.W(W)) u_csa (
            .x     (v1),
            .y     (v2_w),
            .z     (v4_w),
            .sum   (fin_p),
            .carry (fin_q)
        );
    end else begin : g_chain
        logic [W-1:0] s0, k0, s1, k1;

        madd5_csa #(.W(W)) u_csa0 (.x(a),  .y(b),  .z(c), .sum(s0),    .carry(k0));
        madd5_csa #(.W(W)) u_csa1 (.x(s0), .y(k0), .z(d), .sum(s1),    .carry(k1));
        madd5_csa #(.W(W)) u_csa2 (.x(s1), .y(k1), .z(e), .sum(fin_p), .carry(fin_q));
    end

    madd5_cpa #(.W(W)) u_cpa (
        .p   (fin_p),
        .q   (fin_q),
        .sum (y)
    );

    always_comb begin
        if (!$isunknown({a, b, c, d, e})) begin
            assert_mod_sum_R1: assert (y == W'(a + b + c + d + e))
                else $error("modular sum mismatch");
            if (a == '0 && b == '0 && c == '0 && d == '0 && e == '0) begin
                assert_zero_in_R6: assert (y == '0)
                    else $error("nonzero result for zero inputs");
            end
        end
    end

endmodule

// File: tb/madd5_mod_adder_tb.sv
`timescale 1ns/1ps
module madd5_mod_adder_tb;
    import madd5_pkg::*;

    localparam int W = 8;

    typedef struct {
        logic [W-1:0] exp;
        string        tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a = '0, b = '0, c = '0, d = '0, e = '0;
    logic [W-1:0] y, y_ref;
    item_t        q[$];
    int           checks = 0;
    int           errors = 0;
    bit           done   = 1'b0;

    always #4 clk = ~clk;

    madd5_mod_adder #(.W(W), .ARCH(ARCH_COUNTER)) u_dut (
        .a(a), .b(b), .c(c), .d(d), .e(e), .y(y)
    );

    madd5_mod_adder #(.W(W), .ARCH(ARCH_CSA_CHAIN)) u_ref (
        .a(a), .b(b), .c(c), .d(d), .e(e), .y(y_ref)
    );

    task automatic drive(input logic [W-1:0] ia, ib, ic, id, ie, input string tag);
        logic [W+2:0] full;
        item_t        it;
        @(negedge clk);
        a = ia; b = ib; c = ic; d = id; e = ie;
        full   = ia + ib + ic + id + ie;
        it.exp = full[W-1:0];
        it.tag = tag;
        q.push_back(it);
    endtask

    // monitor: results sampled at the posedge after each negedge drive
    always @(posedge clk) begin
        if (!rst && q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (y !== it.exp) begin
                errors++;
                $display("FAIL %s: y=%0h expected %0h", it.tag, y, it.exp);
            end
            checks++;
            if (y_ref !== it.exp) begin
                errors++;
                $display("FAIL R5 chain variant (%s): y=%0h expected %0h", it.tag, y_ref, it.exp);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [W-1:0] ones;
        logic [W-1:0] top;
        ones = '1;
        top  = W'(1) << (W - 1);

        // reset state: zero inputs give zero (R6)
        repeat (2) @(negedge clk);
        checks++;
        if (y !== '0) begin
            errors++;
            $display("FAIL R6 reset state: y=%0h expected 0", y);
        end
        rst = 1'b0;

        drive('0, '0, '0, '0, '0, "R6 zero operands");
        drive(ones, ones, ones, ones, ones, "R3 all-ones wrap");
        drive(top, top, top, top, top, "R4 top column full");
        drive(top, top, top, '0, '0, "R4 top column three");

        // single-column counts k = 1..5 at every position (R2)
        for (int i = 0; i < W; i++) begin
            for (int k = 1; k <= 5; k++) begin
                logic [W-1:0] bit_v;
                bit_v = W'(1) << i;
                drive(bit_v,
                      (k > 1) ? bit_v : '0,
                      (k > 2) ? bit_v : '0,
                      (k > 3) ? bit_v : '0,
                      (k > 4) ? bit_v : '0,
                      "R2 single column count");
            end
        end

        drive(8'h55, 8'hAA, 8'h55, 8'hAA, 8'h55, "R1 alternating");
        drive(8'hFF, 8'h01, 8'h00, 8'h00, 8'h00, "R1 carry ripple");
        drive(8'h7F, 8'h7F, 8'h7F, 8'h7F, 8'h7F, "R1 near-full");

        for (int n = 0; n < 300; n++) begin
            drive(W'($urandom), W'($urandom), W'($urandom),
                  W'($urandom), W'($urandom), "R1 random");
        end

        @(negedge clk);
        while (q.size() > 0) @(negedge clk);
        finish_run();
    end

endmodule